// File: doc/BRIEF.md
# Reorderable Pixel Filter Chain

This block streams 8-bit RGB pixels through four point operations: a brightness offset, a channel inversion, a contrast gain around mid-grey and a false-colour map driven by luminance. All four are always in the path. A control word sets their order at run time. Each operation is one registered stage. A router in front of every stage picks that stage's source from its chain position: the raw input for position 0, or the stage one position earlier for any other position. The output is taken from the stage at position 3.

Both pixel ports use valid/ready. An input pixel is accepted on a rising edge where `in_valid` and `in_ready` are both high. An output pixel is taken on an edge where `out_valid` and `out_ready` are both high. The chain moves as one unit. It advances whenever the output is empty or being taken, so `in_ready` follows that advance condition. While a stall lasts, every stage holds. The order word and the two filter parameters are plain inputs, captured on every clock edge. An order word that is not a permutation is rejected: the order in use stays as it was and an error flag is shown.

Top module: `pix_filter_chain`

## Requirements
- R1: After reset `out_valid` and `order_err` are low, `in_ready` is high, and the order in use is brightness, invert, contrast, pseudo-colour (order word 0x1B).
- R2: The order word gives each filter's chain position (0 to 3) in a 2-bit field: brightness bits [7:6], invert [5:4], contrast [3:2], pseudo-colour [1:0].
- R3: The filter at position 0 takes the input pixel. The filter at position k>0 takes the output of the filter at position k-1. The output port shows the filter at position 3. R, G and B follow the same route.
- R4: Brightness adds the signed 9-bit `bright_off` to each channel and clamps the result to 0..255.
- R5: Invert maps each channel x to 255-x.
- R6: Contrast maps each channel x to floor((x-128)*gain/16)+128, clamped to 0..255, with `con_gain` unsigned (16 = unity).
- R7: Pseudo-colour forms y=(R+2G+B)>>2 and t=4*(y mod 64), and selects a band from y>>6. Band 0 gives (0,t,255), band 1 gives (0,255,255-t), band 2 gives (t,255,0) and band 3 gives (255,255-t,0).
- R8: A pixel accepted on edge k is presented with `out_valid` high from edge k+3. Back-to-back pixels come out on consecutive cycles.
- R9: While `out_valid` is high and `out_ready` is low, the output pixel holds, `in_ready` is low, and no pixel is lost or reordered.
- R10: If two fields of `order_cfg` are equal, the previous order stays in use and `order_err` is high from the next edge. A valid word clears the flag on the next edge.
- R11: Order and parameter changes need no reset. They are captured on the next edge and apply to pixels accepted after that edge, once the earlier pixels have left the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Chain can accept a pixel |
| in_r | input | 8 | Input red |
| in_g | input | 8 | Input green |
| in_b | input | 8 | Input blue |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the pixel |
| out_r | output | 8 | Output red |
| out_g | output | 8 | Output green |
| out_b | output | 8 | Output blue |
| order_cfg | input | 8 | Chain order word |
| bright_off | input | 9 | Signed brightness offset |
| con_gain | input | 8 | Contrast gain, 4 fractional bits |
| order_err | output | 1 | Rejected order word flag |

## Verification
The hardest state to reach is a full chain under stall: all four stages hold different pixels, a fifth pixel waits at the input, and the bench must show that nothing moves or gets lost. The stimulus drops `out_ready` and feeds pixels back to back until `in_ready` falls. It then holds the stall for several cycles before releasing it, and checks that the five results come out in order. A second hard case is a rejected order word that arrives after a non-identity order. The bench loads a reversed chain, applies a duplicate-field word, and checks that a pixel still follows the reversed chain.

// File: rtl/pfp_pkg.sv
package pfp_pkg;
  localparam int PIX_W = 8;
  localparam int NUM_F = 4;
  localparam int POS_W = $clog2(NUM_F);
  localparam int ORD_W = NUM_F * POS_W;

  localparam int F_BRI = 0;
  localparam int F_INV = 1;
  localparam int F_CON = 2;
  localparam int F_PSE = 3;

  typedef logic [PIX_W-1:0] chan_t;
  typedef chan_t [2:0] rgb_t;  // [0]=R [1]=G [2]=B

  function automatic logic [ORD_W-1:0] ident_order();
    logic [ORD_W-1:0] r;
    r = '0;
    for (int f = 0; f < NUM_F; f++) r[(NUM_F-1-f)*POS_W +: POS_W] = POS_W'(f);
    return r;
  endfunction
endpackage

// File: rtl/pfp_order_reg.sv
module pfp_order_reg import pfp_pkg::*; (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ORD_W-1:0]                order_i,
  output logic                            err_q,
  output logic [NUM_F-1:0][POS_W-1:0]     pos_of,
  output logic [NUM_F-1:0][POS_W-1:0]     who_at
);
  localparam logic [ORD_W-1:0] ORD_RST = ident_order();

  logic [ORD_W-1:0] order_q;
  logic [NUM_F-1:0] occ_in, occ_q;
  logic             ok_in;

  always_comb begin
    occ_in = '0;
    for (int f = 0; f < NUM_F; f++) occ_in[order_i[(NUM_F-1-f)*POS_W +: POS_W]] = 1'b1;
    ok_in = &occ_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      order_q <= ORD_RST;
      err_q   <= 1'b0;
    end else begin
      err_q <= !ok_in;
      if (ok_in) order_q <= order_i;
    end
  end

  for (genvar f = 0; f < NUM_F; f++) begin : g_pos
    assign pos_of[f] = order_q[(NUM_F-1-f)*POS_W +: POS_W];
  end

  always_comb begin
    who_at = '0;
    occ_q  = '0;
    for (int p = 0; p < NUM_F; p++)
      for (int f = 0; f < NUM_F; f++)
        if (pos_of[f] == POS_W'(p)) begin
          who_at[p] = POS_W'(f);
          occ_q[p]  = 1'b1;
        end
  end

  // R10
  order_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(occ_q) == NUM_F);
  // R10
  order_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $stable(order_q));
endmodule

// File: rtl/pfp_route.sv
module pfp_route import pfp_pkg::*; (
  input  logic                        in_v,
  input  rgb_t                        in_px,
  input  logic [NUM_F-1:0]            st_v,
  input  rgb_t [NUM_F-1:0]            st_px,
  input  logic [NUM_F-1:0][POS_W-1:0] pos_of,
  input  logic [NUM_F-1:0][POS_W-1:0] who_at,
  output logic [NUM_F-1:0]            src_v,
  output rgb_t [NUM_F-1:0]            src_px,
  output logic                        fin_v,
  output rgb_t                        fin_px
);
  always_comb begin
    for (int f = 0; f < NUM_F; f++) begin
      if (pos_of[f] == '0) begin
        src_v[f]  = in_v;
        src_px[f] = in_px;
      end else begin
        src_v[f]  = st_v[who_at[pos_of[f] - 1'b1]];
        src_px[f] = st_px[who_at[pos_of[f] - 1'b1]];
      end
    end
    fin_v  = st_v[who_at[NUM_F-1]];
    fin_px = st_px[who_at[NUM_F-1]];
  end
endmodule

// File: rtl/pfp_stage.sv
module pfp_stage import pfp_pkg::*; #(
  parameter int KIND      = F_BRI,
  parameter int OFF_W     = 9,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv,
  input  logic                    src_v,
  input  rgb_t                    src_px,
  input  logic signed [OFF_W-1:0] off,
  input  logic [GAIN_W-1:0]       gain,
  output logic                    out_v,
  output rgb_t                    out_px
);
  localparam int MAXV = (1 << PIX_W) - 1;
  localparam int MID  = 1 << (PIX_W - 1);
  localparam int SW   = (OFF_W > PIX_W + 1) ? OFF_W + 1 : PIX_W + 2;
  localparam int DW   = PIX_W + 1;
  localparam int PW   = PIX_W + GAIN_W + 2;

  rgb_t nxt;
  logic unused_par;
  assign unused_par = ^{off, gain};

  if (KIND == F_BRI) begin : g_bri
    always_comb begin
      logic signed [SW-1:0] s;
      for (int c = 0; c < 3; c++) begin
        s = SW'($signed({1'b0, src_px[c]})) + SW'(off);
        if (s[SW-1])             nxt[c] = '0;
        else if (s > SW'(MAXV))  nxt[c] = '1;
        else                     nxt[c] = s[PIX_W-1:0];
      end
    end
  end else if (KIND == F_INV) begin : g_inv
    always_comb for (int c = 0; c < 3; c++) nxt[c] = ~src_px[c];
  end else if (KIND == F_CON) begin : g_con
    always_comb begin
      logic signed [DW-1:0] d;
      logic signed [PW-1:0] p, q;
      for (int c = 0; c < 3; c++) begin
        d = $signed({1'b0, src_px[c]}) - DW'(MID);
        p = PW'(d) * PW'($signed({1'b0, gain}));
        q = (p >>> GAIN_FRAC) + PW'(MID);
        if (q[PW-1])            nxt[c] = '0;
        else if (q > PW'(MAXV)) nxt[c] = '1;
        else                    nxt[c] = q[PIX_W-1:0];
      end
    end
  end else begin : g_pse
    always_comb begin
      logic [PIX_W+1:0] sum;
      chan_t            y, t;
      sum = {2'b0, src_px[0]} + {1'b0, src_px[1], 1'b0} + {2'b0, src_px[2]};
      y   = sum[PIX_W+1:2];
      t   = {y[PIX_W-3:0], 2'b00};
      case (y[PIX_W-1 -: 2])
        2'd0:    begin nxt[0] = '0; nxt[1] = t;       nxt[2] = '1;      end
        2'd1:    begin nxt[0] = '0; nxt[1] = '1;      nxt[2] = ~t;      end
        2'd2:    begin nxt[0] = t;  nxt[1] = '1;      nxt[2] = '0;      end
        default: begin nxt[0] = '1; nxt[1] = ~t;      nxt[2] = '0;      end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v  <= 1'b0;
      out_px <= '0;
    end else if (adv) begin
      out_v <= src_v;
      if (src_v) out_px <= nxt;
    end
  end

  // R8
  stage_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv && src_v |=> out_v);
  // R9
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(out_v) && $stable(out_px));
endmodule

// File: rtl/pix_filter_chain.sv
module pix_filter_chain import pfp_pkg::*; #(
  parameter int OFF_W     = 9,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [PIX_W-1:0]        in_r,
  input  logic [PIX_W-1:0]        in_g,
  input  logic [PIX_W-1:0]        in_b,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [PIX_W-1:0]        out_r,
  output logic [PIX_W-1:0]        out_g,
  output logic [PIX_W-1:0]        out_b,
  input  logic [ORD_W-1:0]        order_cfg,
  input  logic signed [OFF_W-1:0] bright_off,
  input  logic [GAIN_W-1:0]       con_gain,
  output logic                    order_err
);
  logic                        adv;
  rgb_t                        in_px, fin_px;
  logic                        fin_v;
  logic [NUM_F-1:0]            st_v, src_v;
  rgb_t [NUM_F-1:0]            st_px, src_px;
  logic [NUM_F-1:0][POS_W-1:0] pos_of, who_at;
  logic signed [OFF_W-1:0]     off_q;
  logic [GAIN_W-1:0]           gain_q;

  assign in_px[0] = in_r;
  assign in_px[1] = in_g;
  assign in_px[2] = in_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q  <= '0;
      gain_q <= GAIN_W'(1 << GAIN_FRAC);
    end else begin
      off_q  <= bright_off;
      gain_q <= con_gain;
    end
  end

  pfp_order_reg u_ord (
    .clk(clk), .rst_n(rst_n), .order_i(order_cfg),
    .err_q(order_err), .pos_of(pos_of), .who_at(who_at)
  );

  pfp_route u_route (
    .in_v(in_valid), .in_px(in_px), .st_v(st_v), .st_px(st_px),
    .pos_of(pos_of), .who_at(who_at), .src_v(src_v), .src_px(src_px),
    .fin_v(fin_v), .fin_px(fin_px)
  );

  for (genvar f = 0; f < NUM_F; f++) begin : g_stage
    pfp_stage #(.KIND(f), .OFF_W(OFF_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)) u_st (
      .clk(clk), .rst_n(rst_n), .adv(adv), .src_v(src_v[f]), .src_px(src_px[f]),
      .off(off_q), .gain(gain_q), .out_v(st_v[f]), .out_px(st_px[f])
    );
  end

  assign out_valid = fin_v;
  assign out_r     = fin_px[0];
  assign out_g     = fin_px[1];
  assign out_b     = fin_px[2];
  assign adv       = out_ready || !fin_v;
  assign in_ready  = adv;

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable({out_r, out_g, out_b}));
  // R9
  in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
endmodule

// File: tb/tb_pix_filter_chain.sv
module tb_pix_filter_chain;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0, out_ready = 1'b1;
  logic              in_ready, out_valid, order_err;
  logic [7:0]        in_r = '0, in_g = '0, in_b = '0;
  logic [7:0]        out_r, out_g, out_b;
  logic [7:0]        order_cfg = 8'h1B;
  logic signed [8:0] bright_off = '0;
  logic [7:0]        con_gain = 8'd16;

  int ncmp = 0, nfail = 0;
  bit done = 0;

  pix_filter_chain dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_r(in_r), .in_g(in_g), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_r(out_r), .out_g(out_g), .out_b(out_b),
    .order_cfg(order_cfg), .bright_off(bright_off), .con_gain(con_gain),
    .order_err(order_err)
  );

  typedef struct packed {
    logic [7:0]        ord;
    logic signed [8:0] off;
    logic [7:0]        gain;
    logic [23:0]       px;
    logic [23:0]       exp;
  } vec_t;

  // order/offset/gain changed between entries without reset: R11
  localparam vec_t VEC [10] = '{
    '{8'h1B,  9'sd0,   8'd16, 24'h000000, 24'hFF0300},  // R2 R5 R7 band 3
    '{8'h1B,  9'sd0,   8'd16, 24'hFFFFFF, 24'h0000FF},  // R7 band 0
    '{8'h6C,  9'sd0,   8'd16, 24'h646464, 24'hFF0090},  // R3 pseudo first
    '{8'h1B,  9'sd100, 8'd16, 24'hC80A00, 24'h00FF43},  // R4 clamp high
    '{8'h1B, -9'sd50,  8'd16, 24'h1E3CFF, 24'hFFE700},  // R4 clamp low
    '{8'h63,  9'sd0,   8'd32, 24'h6480C8, 24'h00FF4B},  // R6 gain 2
    '{8'h63,  9'sd0,   8'd0,  24'h07FA21, 24'h00FF03},  // R6 gain 0
    '{8'h63,  9'sd0,   8'd8,  24'h018100, 24'h7CFF00},  // R6 negative floor, R7 band 2
    '{8'hE4,  9'sd10,  8'd16, 24'h000000, 24'hFFFF0A},  // R3 reversed chain
    '{8'hE4, -9'sd20,  8'd16, 24'hFFFFFF, 24'h00E8EB}   // R3 R4
  };

  function automatic int sat(int v);
    return (v < 0) ? 0 : (v > 255) ? 255 : v;
  endfunction

  function automatic logic [23:0] model(logic [7:0] o, int off, int g, logic [23:0] px);
    int ch[3];
    int y, t;
    ch[0] = int'(px[23:16]); ch[1] = int'(px[15:8]); ch[2] = int'(px[7:0]);
    for (int p = 0; p < 4; p++)
      for (int f = 0; f < 4; f++)
        if (int'(o[(3-f)*2 +: 2]) == p) begin
          if (f == 0) for (int c = 0; c < 3; c++) ch[c] = sat(ch[c] + off);
          else if (f == 1) for (int c = 0; c < 3; c++) ch[c] = 255 - ch[c];
          else if (f == 2) for (int c = 0; c < 3; c++) ch[c] = sat((((ch[c] - 128) * g) >>> 4) + 128);
          else begin
            y = (ch[0] + 2*ch[1] + ch[2]) >> 2;
            t = (y % 64) * 4;
            case (y / 64)
              0: begin ch[0] = 0;   ch[1] = t;       ch[2] = 255;     end
              1: begin ch[0] = 0;   ch[1] = 255;     ch[2] = 255 - t; end
              2: begin ch[0] = t;   ch[1] = 255;     ch[2] = 0;       end
              default: begin ch[0] = 255; ch[1] = 255 - t; ch[2] = 0; end
            endcase
          end
        end
    return {ch[0][7:0], ch[1][7:0], ch[2][7:0]};
  endfunction

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    ncmp++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic cfg(input logic [7:0] o, input logic signed [8:0] f, input logic [7:0] g);
    @(negedge clk);
    order_cfg = o; bright_off = f; con_gain = g;
  endtask

  task automatic drive(input logic v, input logic [23:0] px);
    in_valid = v; {in_r, in_g, in_b} = px;
  endtask

  task automatic send_one(input logic [23:0] px, input logic [23:0] exp, input string rq);
    @(negedge clk); drive(1'b1, px);
    @(negedge clk); drive(1'b0, '0);
    repeat (3) @(negedge clk);
    chk(rq, "out_valid", 32'(out_valid), 32'd1);
    chk(rq, "pixel", 32'({out_r, out_g, out_b}), 32'(exp));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL R8 watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
      $finish;
    end
  end

  initial begin
    logic [23:0] bp_exp [5];
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1", "out_valid in reset", 32'(out_valid), 32'd0);
    chk("R1", "order_err in reset", 32'(order_err), 32'd0);
    chk("R1", "in_ready in reset", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    // R1 default order without writing a new word
    order_cfg = 8'h1B;
    send_one(24'h000000, 24'hFF0300, "R1");

    // vector table: R2 R3 R4 R5 R6 R7 R11
    for (int i = 0; i < 10; i++) begin
      cfg(VEC[i].ord, VEC[i].off, VEC[i].gain);
      send_one(VEC[i].px, VEC[i].exp, $sformatf("R3/R4/R5/R6/R7 vec%0d", i));
    end

    // R8 latency
    cfg(8'h1B, 9'sd0, 8'd16);
    @(negedge clk); drive(1'b1, 24'h102030);
    @(negedge clk); drive(1'b0, '0);
    chk("R8", "valid at k+1", 32'(out_valid), 32'd0);
    @(negedge clk); chk("R8", "valid at k+2", 32'(out_valid), 32'd0);
    @(negedge clk); chk("R8", "valid at k+3 early", 32'(out_valid), 32'd0);
    @(negedge clk); chk("R8", "valid appears", 32'(out_valid), 32'd1);
    @(negedge clk); chk("R8", "single beat", 32'(out_valid), 32'd0);

    // R8 back-to-back stream
    cfg(8'h63, 9'sd7, 8'd24);
    for (int j = 0; j < 10; j++) begin
      logic [23:0] px;
      @(negedge clk);
      if (j >= 4) begin
        px = {8'((j-4)*40), 8'(255-(j-4)*30), 8'((j-4)*17)};
        chk("R8", "stream valid", 32'(out_valid), 32'd1);
        chk("R8", "stream pixel", 32'({out_r, out_g, out_b}), 32'(model(8'h63, 7, 24, px)));
      end
      if (j < 6) drive(1'b1, {8'(j*40), 8'(255-j*30), 8'(j*17)});
      else drive(1'b0, '0);
    end

    // R9 back-pressure
    cfg(8'h1B, 9'sd5, 8'd16);
    for (int k = 0; k < 5; k++) bp_exp[k] = model(8'h1B, 5, 16, {8'(k*50), 8'(k*11+3), 8'(200-k*9)});
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      out_ready = 1'b0;
      chk("R9", "in_ready while filling", 32'(in_ready), 32'd1);
      drive(1'b1, {8'(k*50), 8'(k*11+3), 8'(200-k*9)});
    end
    @(negedge clk);
    drive(1'b1, {8'(200), 8'(47), 8'(164)});
    chk("R9", "in_ready full", 32'(in_ready), 32'd0);
    chk("R9", "out_valid full", 32'(out_valid), 32'd1);
    chk("R9", "head pixel", 32'({out_r, out_g, out_b}), 32'(bp_exp[0]));
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk("R9", "held in_ready", 32'(in_ready), 32'd0);
      chk("R9", "held pixel", 32'({out_r, out_g, out_b}), 32'(bp_exp[0]));
    end
    @(negedge clk);
    out_ready = 1'b1;
    for (int k = 1; k < 5; k++) begin
      @(negedge clk);
      drive(1'b0, '0);
      chk("R9", "drain valid", 32'(out_valid), 32'd1);
      chk("R9", "drain order", 32'({out_r, out_g, out_b}), 32'(bp_exp[k]));
    end
    @(negedge clk);
    chk("R9", "drained", 32'(out_valid), 32'd0);

    // R10 rejected order words keep a non-identity order
    cfg(8'hE4, 9'sd10, 8'd16);
    cfg(8'h00, 9'sd10, 8'd16);
    @(negedge clk);
    chk("R10", "err on all-equal word", 32'(order_err), 32'd1);
    send_one(24'h000000, 24'hFFFF0A, "R10");
    chk("R10", "err stays", 32'(order_err), 32'd1);
    cfg(8'h1B, 9'sd0, 8'd16);
    @(negedge clk);
    chk("R10", "err cleared", 32'(order_err), 32'd0);
    cfg(8'h1A, 9'sd0, 8'd16);
    @(negedge clk);
    chk("R10", "err on two equal fields", 32'(order_err), 32'd1);
    send_one(24'h000000, 24'hFF0300, "R10");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
    $finish;
  end
endmodule